// File: doc/BRIEF.md
# Hourly chime tone generator

This block drives a buzzer at the top of every hour for a digital wall clock. It watches the four BCD digits of minutes and seconds that the clock's counters present. When those digits reach 00:00 and the clock is running (not in set mode), it starts a one-shot timer. For a fixed number of seconds the timer lets a square-wave tone through to the buzzer pin. Outside that window the pin is held low.

The tone is a divided-down copy of the system clock. With the default 12 MHz clock the divider toggles every 1000 cycles, which gives a 6 kHz square wave. The one-shot length is a whole number of seconds, counted in system-clock cycles from the moment the chime starts. A match is acted on only at its rising edge, so a 00:00 that is held starts the chime once. A 00:00 reached while the clock is in set mode never sounds, nor does one that is already present when running resumes.

Top module: `hourly_chime`

## Requirements
- R1: While rst_ni is low, buzz_o is 0. Leaving reset with all four digits already 0 and run_i=1 does not start a chime.
- R2: While a chime is active, buzz_o is a square wave with half-period HALF = CLK_HZ/(2*TONE_HZ) cycles. It is 0 for the first HALF cycles after the start edge, then 1 for HALF cycles, and so on.
- R3: A chime starts on the clock edge that first samples min_tens_i, min_ones_i, sec_tens_i and sec_ones_i all equal to 4'd0 with run_i=1, when the previous edge sampled at least one nonzero digit.
- R4: A chime lasts exactly CHIME_SECS*CLK_HZ clock cycles from its start edge. After that, buzz_o is held at 0.
- R5: Digits held at 00:00 start only one chime, including after that chime ends.
- R6: A new 00:00 edge that arrives while a chime is active, and is not on its final cycle, is ignored. It neither extends nor restarts the chime.
- R7: With run_i=0, a 00:00 edge does not start a chime. Setting run_i back to 1 while the digits stay 00:00 does not start one either.
- R8: Times that are only partly zero, such as 00:01, 00:10, 01:00 and 10:00, do not start a chime.
- R9: A 00:00 edge sampled on the same edge on which an active chime expires starts a fresh chime, with the tone phase restarted.
- R10: Asserting rst_ni low during a chime forces buzz_o to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 = clock running, 0 = set mode |
| min_tens_i | input | 4 | BCD tens digit of minutes |
| min_ones_i | input | 4 | BCD units digit of minutes |
| sec_tens_i | input | 4 | BCD tens digit of seconds |
| sec_ones_i | input | 4 | BCD units digit of seconds |
| buzz_o | output | 1 | Buzzer drive: gated square wave, 0 when idle |

## Verification
Two things can happen on the same clock edge: the one-shot expiring and a new 00:00 edge arriving. The bench provokes this by moving the digits away from 00:00 during a chime and returning them so that the match is sampled exactly on the expiring edge. It passes if buzz_o goes on with a full new chime whose tone phase starts again from low. A companion case returns the match one cycle earlier; it must be ignored, so the chime ends on its original schedule.

// File: rtl/chime_pkg.sv
package chime_pkg;
  typedef logic [3:0] bcd_t;
  localparam int N_DIGITS = 4;
endpackage

// File: rtl/chime_hour_detect.sv
module chime_hour_detect
  import chime_pkg::*;
#(
  parameter int N_DIG = N_DIGITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  bcd_t [N_DIG-1:0]      digits_i,
  output logic                  hit_o
);
  logic [N_DIG-1:0] dig_zero;
  logic             all_zero;
  logic             zero_q;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    assign dig_zero[g] = (digits_i[g] == '0);
  end

  assign all_zero = &dig_zero;

  // history resets to "was zero": a clock released at 00:00 stays silent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zero_q <= 1'b1;
    else         zero_q <= all_zero;
  end

  // edge taken on the raw compare so resuming at 00:00 does not fire
  assign hit_o = all_zero & ~zero_q & run_i;

  // R5
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/chime_oneshot.sv
module chime_oneshot #(
  parameter int CLK_HZ = 12_000_000,
  parameter int SECS   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic restart_o
);
  localparam int TICK_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam int SEC_W  = $clog2(SECS + 1);

  logic [TICK_W-1:0] pre_q;
  logic [SEC_W-1:0]  cnt_q;
  logic              tick_w, expire_w, accept_w;

  assign tick_w    = (pre_q == TICK_W'(CLK_HZ - 1));
  assign active_o  = (cnt_q != '0);
  assign expire_w  = (cnt_q == SEC_W'(1)) & tick_w;
  // a start on the expiring cycle re-arms; earlier ones are dropped
  assign accept_w  = start_i & (~active_o | expire_w);
  assign restart_o = accept_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (accept_w) begin
      pre_q <= '0;
      cnt_q <= SEC_W'(SECS);
    end else if (active_o) begin
      if (tick_w) begin
        pre_q <= '0;
        cnt_q <= cnt_q - SEC_W'(1);
      end else begin
        pre_q <= pre_q + TICK_W'(1);
      end
    end else begin
      pre_q <= '0;
    end
  end

  // R3
  arm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> (cnt_q == SEC_W'(SECS)));
  // R6
  no_extend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !expire_w) |=> (cnt_q <= $past(cnt_q)));
  // R4
  expire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_w && !start_i) |=> !active_o);
endmodule

// File: rtl/chime_tone.sv
module chime_tone #(
  parameter int HALF = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic wave_o
);
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DIV_W-1:0] div_q;
  logic             phase_q;
  logic             wrap_w;

  assign wrap_w = (div_q == DIV_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (restart_i || !en_i) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap_w) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q   <= div_q + DIV_W'(1);
    end
  end

  assign wave_o = phase_q;

  // R2
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && !wrap_w) |=> $stable(phase_q));
  // R4
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> !phase_q);
endmodule

// File: rtl/hourly_chime.sv
module hourly_chime
  import chime_pkg::*;
#(
  parameter int CLK_HZ     = 12_000_000,
  parameter int TONE_HZ    = 6000,
  parameter int CHIME_SECS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] min_tens_i,
  input  logic [3:0] min_ones_i,
  input  logic [3:0] sec_tens_i,
  input  logic [3:0] sec_ones_i,
  output logic       buzz_o
);
  localparam int HALF = CLK_HZ / (2 * TONE_HZ);

  bcd_t [N_DIGITS-1:0] digits;
  logic                hit, chime_active, chime_restart, wave;

  assign digits = {min_tens_i, min_ones_i, sec_tens_i, sec_ones_i};

  chime_hour_detect #(.N_DIG(N_DIGITS)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .digits_i (digits),
    .hit_o    (hit)
  );

  chime_oneshot #(.CLK_HZ(CLK_HZ), .SECS(CHIME_SECS)) u_oneshot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (hit),
    .active_o  (chime_active),
    .restart_o (chime_restart)
  );

  chime_tone #(.HALF(HALF)) u_tone (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (chime_active),
    .restart_i (chime_restart),
    .wave_o    (wave)
  );

  assign buzz_o = chime_active & wave;

  // R7
  set_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !chime_active) |=> !chime_active);
endmodule

// File: tb/hourly_chime_tb.sv
module hourly_chime_tb;
  localparam int CLK_HZ  = 1200;
  localparam int TONE_HZ = 100;
  localparam int SECS    = 2;
  localparam int HALF    = CLK_HZ / (2 * TONE_HZ);
  localparam int N       = SECS * CLK_HZ;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 1'b1;
  logic [15:0] t = 16'h0000;
  logic        buzz;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  hourly_chime #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .CHIME_SECS(SECS)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .min_tens_i (t[15:12]),
    .min_ones_i (t[11:8]),
    .sec_tens_i (t[7:4]),
    .sec_ones_i (t[3:0]),
    .buzz_o     (buzz)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic exp_buzz(int k, int first, int restart_at);
    int base;
    base = first;
    if (restart_at >= 0 && k >= restart_at) base = restart_at;
    if (base < 0) return 1'b0;
    if (k - base >= N) return 1'b0;
    return (((k - base) / HALF) % 2) == 1;
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s buzz=%b expected=%b", tag, act, exp);
    end
  endtask

  // k counts negedges after the start edge; stimulus changes land on edge k+1
  task automatic window(string tag, int len, int first, int restart_at,
                        int at1, logic [15:0] v1, int at2, logic [15:0] v2);
    int   bad_k;
    logic bad_a, bad_e, e;
    bad_k = -1;
    bad_a = 1'b0;
    bad_e = 1'b0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      e = exp_buzz(k, first, restart_at);
      if (buzz !== e && bad_k < 0) begin
        bad_k = k; bad_a = buzz; bad_e = e;
      end
      if (k == at1) t = v1;
      if (k == at2) t = v2;
    end
    checks++;
    if (bad_k >= 0) begin
      failures++;
      $display("FAIL %s at k=%0d buzz=%b expected=%b", tag, bad_k, bad_a, bad_e);
    end
  endtask

  task automatic arm();
    @(negedge clk);
    t = 16'h0005;
    repeat (3) @(negedge clk);
    t = 16'h0000;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_bit("R1 in reset", buzz, 1'b0);
    rst_ni = 1'b1;
    window("R1 release at 00:00", 60, -1, -1, -1, '0, -1, '0);
  endtask

  task automatic t_basic();
    arm();
    window("R3 R2 R4 R5 basic chime", N + 100, 0, -1, -1, '0, -1, '0);
  endtask

  task automatic t_no_extend();
    arm();
    window("R6 mid retrigger", N + 60, 0, -1, 100, 16'h0001, 200, 16'h0000);
    arm();
    window("R6 retrigger one before end", N + 60, 0, -1, 10, 16'h0001, N - 2, 16'h0000);
  endtask

  task automatic t_collide();
    arm();
    window("R9 retrigger on expiry", 2 * N + 60, 0, N, 10, 16'h0001, N - 1, 16'h0000);
  endtask

  task automatic t_set_mode();
    @(negedge clk);
    t = 16'h0005;
    run = 1'b0;
    repeat (3) @(negedge clk);
    t = 16'h0000;
    window("R7 set mode at 00:00", 60, -1, -1, -1, '0, -1, '0);
    run = 1'b1;
    window("R7 resume at 00:00", 60, -1, -1, -1, '0, -1, '0);
  endtask

  task automatic t_partial();
    logic [15:0] vals [4];
    vals = '{16'h0001, 16'h0010, 16'h0100, 16'h1000};
    foreach (vals[i]) begin
      @(negedge clk);
      t = 16'h0005;
      repeat (3) @(negedge clk);
      t = vals[i];
      window("R8 partial zero", 40, -1, -1, -1, '0, -1, '0);
    end
  endtask

  task automatic t_async_reset();
    arm();
    window("R10 before reset", 21, 0, -1, -1, '0, -1, '0);
    #1 rst_ni = 1'b0;
    #1 check_bit("R10 async clear", buzz, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    window("R10 R1 after reset", 60, -1, -1, -1, '0, -1, '0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_no_extend();
    t_collide();
    t_set_mode();
    t_partial();
    t_async_reset();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule